// File: doc/BRIEF.md
# Offset-Based Tick Counter Register

This block presents a 64-bit timer register whose running value is never counted locally. An external free-running event count (for example, retired instructions) enters on a port. The register holds only a 63-bit offset and a single flag bit. A write records the difference between the supplied value and the event count in that cycle. A read adds the live count back to the offset. The read therefore advances in step with the external count, as if the register itself were counting from the written value.

Bit 63 is a separately held interrupt-disable flag. It is stored as written and returned unchanged. The two least significant bits of every read are forced to zero. Three read selects return the same value: the tick alias, the system-tick alias and the privileged-tick alias. Writes are accepted only through the first two. Compare registers and match interrupts are not part of this block.

Top module: `tick_offset_reg`

## Requirements
- R1: After reset, the flag bit (bit 63) reads 1 and the offset is 0, so a read returns {1, count[62:2], 2'b00}.
- R2: A write on a clock edge stores offset = wr_data[62:0] - evt_count[62:0], using the event count present in that same cycle, modulo 2^63.
- R3: A write stores wr_data[63] as the flag bit, and every later read returns it in bit 63.
- R4: Bits 1:0 of a read through a valid select are always 0.
- R5: Read selects 0 (tick), 1 (system tick) and 2 (privileged tick) all return the same value.
- R6: Writes with wr_addr 0 or 1 have identical effect. Writing V and then advancing the count by N reads back {V[63], (V[62:0]+N)[62:2], 2'b00}.
- R7: A write with wr_addr 2 or any select above 2 changes neither the offset nor the flag.
- R8: For a read select above 2, rd_hit is 0 and rd_data is all zeros. For selects 0 to 2, rd_hit is 1.
- R9: The low 63 bits of the sum wrap modulo 2^63 without disturbing bit 63.
- R10: The read path is combinational: rd_data follows evt_count and rd_addr in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_count | input | 64 | External free-running event count |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write select (0 tick, 1 system tick) |
| wr_data | input | 64 | Value to write |
| rd_addr | input | 3 | Read select (0, 1, 2 alias the register) |
| rd_data | output | 64 | Read value |
| rd_hit | output | 1 | Read select maps to the register |

## Verification
A wrong offset shows at the very next read as a constant error between the returned value and the written value plus elapsed count. The error persists unchanged as the count advances, so one read after any write exposes it. A lost or inverted flag appears at once in bit 63. A leaking low bit or a wrong carry at the 2^63 boundary shows only for particular counts, so the sweep steps the count through every residue mod 4 and writes values close to the wrap point.

// File: rtl/tick_pkg.sv
// Package: shared select codes and widths for the offset tick register.
// Assumes the three read aliases occupy codes 0..2 of a 3-bit select.
package tick_pkg;
    localparam int SEL_W = 3;
    localparam logic [SEL_W-1:0] SEL_TICK     = 3'd0;
    localparam logic [SEL_W-1:0] SEL_SYSTICK  = 3'd1;
    localparam logic [SEL_W-1:0] SEL_PRIVTICK = 3'd2;
endpackage

// File: rtl/tick_sel_decode.sv
// Decodes the write and read selects into enables.
// Assumes: writes accepted through the tick and system-tick codes only;
// reads accepted through all three alias codes.
module tick_sel_decode
    import tick_pkg::*;
(
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_addr,
    input  logic [SEL_W-1:0] rd_addr,
    output logic             wr_ok,
    output logic             rd_ok
);
    // Write enable: only the two writable aliases.
    always_comb wr_ok = wr_en && ((wr_addr == SEL_TICK) || (wr_addr == SEL_SYSTICK));
    // Read hit: any of the three aliases.
    always_comb rd_ok = (rd_addr == SEL_TICK) || (rd_addr == SEL_SYSTICK) ||
                        (rd_addr == SEL_PRIVTICK);
endmodule

// File: rtl/tick_offset_store.sv
// Holds the offset (low W-1 bits) and the separately stored top flag bit.
// Assumes: evt_count is stable around the capturing edge; the offset is
// computed modulo 2^(W-1) from the count of the write cycle.
module tick_offset_store #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_ok,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] evt_count,
    output logic [W-2:0] offset_q,
    output logic         flag_q
);
    localparam int LOW_W = W - 1;

    logic [LOW_W-1:0] offset_d;
    logic             unused_cnt_top;

    // Offset for a write: written value minus the present count.
    always_comb offset_d = wr_data[LOW_W-1:0] - evt_count[LOW_W-1:0];
    always_comb unused_cnt_top = evt_count[W-1];

    // Storage: reset to offset 0 and flag 1, load both on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            offset_q <= '0;
            flag_q   <= 1'b1;
        end else if (wr_ok) begin
            offset_q <= offset_d;
            flag_q   <= wr_data[W-1];
        end
    end

    // R2: the stored offset plus the write-cycle count equals the written low bits.
    assert_offset_diff_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> (LOW_W'(offset_q + $past(evt_count[LOW_W-1:0])) == $past(wr_data[LOW_W-1:0])));
    // R3: the flag follows the written top bit.
    assert_flag_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> (flag_q == $past(wr_data[W-1])));
endmodule

// File: rtl/tick_read_path.sv
// Combinational read: live count plus offset, low bits dropped, flag on top.
// Assumes DROP < W-1; returns zero when the select misses.
module tick_read_path #(
    parameter int W    = 64,
    parameter int DROP = 2
) (
    input  logic [W-1:0] evt_count,
    input  logic [W-2:0] offset_q,
    input  logic         flag_q,
    input  logic         rd_ok,
    output logic [W-1:0] rd_data
);
    localparam int LOW_W = W - 1;

    logic [LOW_W-1:0] sum;
    logic [LOW_W-1:0] shown;
    logic             unused_cnt_top;

    // Modulo 2^(W-1) sum of the count and the offset.
    always_comb sum = evt_count[LOW_W-1:0] + offset_q;
    always_comb unused_cnt_top = evt_count[W-1];

    generate
        if (DROP > 0) begin : g_mask
            // Clear the dropped low bits.
            always_comb shown = {sum[LOW_W-1:DROP], {DROP{1'b0}}};
        end else begin : g_pass
            // No bits dropped.
            always_comb shown = sum;
        end
    endgenerate

    // Output: flag on top, zero when the select misses.
    always_comb rd_data = rd_ok ? {flag_q, shown} : '0;
endmodule

// File: rtl/tick_offset_reg.sv
// Top: offset-based tick register with three read aliases.
// Assumes evt_count advances by at most one per cycle (not required for
// correctness). Writes take effect at the next edge; reads are combinational.
module tick_offset_reg
    import tick_pkg::*;
#(
    parameter int W    = 64,
    parameter int DROP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     evt_count,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_addr,
    input  logic [W-1:0]     wr_data,
    input  logic [SEL_W-1:0] rd_addr,
    output logic [W-1:0]     rd_data,
    output logic             rd_hit
);
    logic         wr_ok;
    logic         rd_ok;
    logic [W-2:0] offset_q;
    logic         flag_q;

    tick_sel_decode u_dec (
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .rd_addr(rd_addr),
        .wr_ok  (wr_ok),
        .rd_ok  (rd_ok)
    );

    tick_offset_store #(.W(W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ok    (wr_ok),
        .wr_data  (wr_data),
        .evt_count(evt_count),
        .offset_q (offset_q),
        .flag_q   (flag_q)
    );

    tick_read_path #(.W(W), .DROP(DROP)) u_read (
        .evt_count(evt_count),
        .offset_q (offset_q),
        .flag_q   (flag_q),
        .rd_ok    (rd_ok),
        .rd_data  (rd_data)
    );

    // Hit flag to the port.
    always_comb rd_hit = rd_ok;

    // R7: a write through the privileged-tick code leaves storage unchanged.
    assert_priv_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == SEL_PRIVTICK)) |=> ((offset_q == $past(offset_q)) && (flag_q == $past(flag_q))));
    // R8: a missing read select returns zero with no hit.
    assert_miss_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr > SEL_PRIVTICK) |-> (!rd_hit && (rd_data == '0)));

    generate
        if (DROP > 0) begin : g_low_chk
            // R4: dropped bits are zero on every hit.
            assert_low_bits_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
                rd_hit |-> (rd_data[DROP-1:0] == '0));
        end
    endgenerate
endmodule

// File: tb/test_tick_offset_reg.sv
module test_tick_offset_reg;
    localparam int W = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] evt_count = '0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic [2:0]   rd_addr = '0;
    logic [W-1:0] rd_data;
    logic         rd_hit;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    tick_offset_reg #(.W(W), .DROP(2)) i_tick_offset_reg (
        .clk(clk), .rst_n(rst_n), .evt_count(evt_count), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_hit(rd_hit)
    );

    function automatic logic [W-1:0] expect_val(logic flag, logic [W-2:0] base, logic [W-2:0] adv);
        logic [W-2:0] s;
        s = base + adv;
        return {flag, s[W-2:2], 2'b00};
    endfunction

    task automatic check(input logic [2:0] sel, input logic [W-1:0] exp, input logic exp_hit, input string req);
        rd_addr = sel;
        #1;
        n_checks++;
        if (rd_data !== exp || rd_hit !== exp_hit) begin
            n_fail++;
            $display("FAIL %s sel=%0d got=%h hit=%b expected=%h hit=%b", req, sel, rd_data, rd_hit, exp, exp_hit);
        end
    endtask

    task automatic set_count(input logic [W-1:0] c);
        @(negedge clk);
        evt_count = c;
    endtask

    task automatic do_write(input logic [2:0] sel, input logic [W-1:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = sel; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        logic [W-1:0] vals [6];
        logic [W-1:0] c0;
        vals[0] = 64'h0000_0000_0000_0000;
        vals[1] = 64'h8000_0000_0000_0003;
        vals[2] = 64'h7FFF_FFFF_FFFF_FFFD;
        vals[3] = 64'hFFFF_FFFF_FFFF_FFFA;
        vals[4] = 64'h1234_5678_9ABC_DEF1;
        vals[5] = 64'hC000_0000_0000_0002;

        evt_count = 64'h0000_0000_0000_0A57;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state read through every alias
        for (int s = 0; s < 3; s++)
            check(3'(s), expect_val(1'b1, evt_count[W-2:0], '0), 1'b1, "R1");
        // R10: combinational read follows count changes in the same cycle
        for (int k = 1; k < 6; k++) begin
            set_count(64'h0A57 + 64'(k));
            check(3'd0, expect_val(1'b1, 63'h0A57, 63'(k)), 1'b1, "R10");
        end

        // R2 R3 R5 R6 R9: write V, advance by N, read all aliases
        for (int vi = 0; vi < 6; vi++) begin
            for (int n = 0; n < 8; n++) begin
                c0 = 64'h7FFF_FFFF_FFFF_FF00 + 64'(vi * 37 + n * 5);
                set_count(c0);
                do_write(3'((vi + n) % 2), vals[vi]);
                set_count(c0 + 64'(n));
                for (int s = 0; s < 3; s++)
                    check(3'(s), expect_val(vals[vi][W-1], vals[vi][W-2:0], 63'(n)), 1'b1,
                          (n % 2 == 0) ? "R2_R6_R9" : "R3_R5");
            end
        end

        // R7: ignored writes via privileged alias and unmapped codes
        set_count(64'h100);
        do_write(3'd0, 64'h0000_0000_0000_5000);
        do_write(3'd2, 64'hFFFF_FFFF_FFFF_FFFF);
        check(3'd0, expect_val(1'b0, 63'h5000, 63'd0), 1'b1, "R7");
        for (int s = 3; s < 8; s++) begin
            do_write(3'(s), 64'hDEAD_BEEF_0000_0000);
            check(3'd1, expect_val(1'b0, 63'h5000, 63'd0), 1'b1, "R7");
        end

        // R8: unmapped reads
        for (int s = 3; s < 8; s++)
            check(3'(s), '0, 1'b0, "R8");

        // R4: low bits zero over every count residue
        for (int k = 0; k < 8; k++) begin
            set_count(64'h100 + 64'(k));
            check(3'd2, expect_val(1'b0, 63'h5000, 63'(k)), 1'b1, "R4");
        end

        // R1: reset again after writes restores flag and zero offset
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check(3'd0, expect_val(1'b1, 63'h107, 63'd0), 1'b1, "R1");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule